// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

The arbiter picks which of a set of transmit mailboxes is sent next on a CAN bus. Each mailbox offers an active-transmit flag, a 29-bit identifier, IDE and RTR bits and a 3-bit local priority. When a scan is triggered, the arbiter visits one mailbox per clock and keeps the best candidate seen so far. At the end of the scan it publishes a winner-valid flag and the winner's index. The previous winner stays on the outputs until a scan completes.

Two mode bits select the sort key. Lowest-buffer mode ranks mailboxes by index alone. Identifier mode ranks them by a 32-bit key that places the RTR, SRR and IDE bits where they appear on the wire. Priority mode puts the local priority above that same key.

Scans are started by frame-phase events from the protocol engine: the CRC field, the error delimiter, intermission and leaving freeze. CPU writes to a mailbox control/status word also start a scan, under the rules below.

Top module: `tx_arb_top`

## Requirements
- R1: With lowest_buf_i = 1, the lowest-numbered active mailbox wins, whatever the identifiers are and whatever the value of prio_en_i.
- R2: With lowest_buf_i = 0 and prio_en_i = 0, the mailbox with the smallest identifier key wins, and the priority inputs have no effect.
- R3: With lowest_buf_i = 0 and prio_en_i = 1, the key is {prio, identifier key}, so a lower priority value wins over any identifier, and the identifier key decides between equal priorities.
- R4: The identifier key is 32 bits wide, and the standard identifier always comes from id bits 28:18.
  - A standard frame (IDE = 0) gives {id[28:18], RTR, 0, 18'b0, 0}.
  - An extended frame (IDE = 1) gives {id[28:18], 1, 1, id[17:0], RTR}.
  - So, for equal base identifiers, a standard frame beats an extended frame, and RTR = 0 beats RTR = 1.
- R5: A one-cycle pulse on ev_crc_i, ev_err_delim_i or ev_freeze_exit_i starts a scan, and busy_o is 1 in the next cycle.
- R6: A pulse on ev_intermission_i starts a scan only in one of two cases:
  - the current winner is valid and its active flag is now 0; or
  - there is no valid winner and a CPU control/status write (cpu_cs_wr_i) has arrived since the last scan started.
- R7: A cpu_cs_wr_i pulse while idle_or_busoff_i = 1 starts a scan. The same pulse with idle_or_busoff_i = 0 does not start a scan.
- R8: If no mailbox is active during a scan, winner_valid_o is 0 when the scan ends.
- R9: If two mailboxes have equal keys, the lower index wins.
- R10: A scan keeps busy_o high for exactly NUM_BUF cycles (16 by default). winner_valid_o and winner_idx_o change only when busy_o falls, and both are 0 after reset.
- R11: A trigger during a scan restarts it from mailbox 0, and busy_o then stays high for a full NUM_BUF cycles after the new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| active_i | input | NUM_BUF | Per-mailbox active-transmit flag |
| id_i | input | NUM_BUF*29 | Identifiers, mailbox n at bits n*29 +: 29 |
| ide_i | input | NUM_BUF | Per-mailbox extended-frame bit |
| rtr_i | input | NUM_BUF | Per-mailbox remote-request bit |
| prio_i | input | NUM_BUF*3 | Local priorities, mailbox n at bits n*3 +: 3 |
| lowest_buf_i | input | 1 | Rank by mailbox index |
| prio_en_i | input | 1 | Prepend local priority to the key |
| ev_crc_i | input | 1 | CRC field event pulse |
| ev_err_delim_i | input | 1 | Error delimiter event pulse |
| ev_intermission_i | input | 1 | Intermission event pulse |
| ev_freeze_exit_i | input | 1 | Freeze exit event pulse |
| idle_or_busoff_i | input | 1 | Protocol engine idle or bus-off level |
| cpu_cs_wr_i | input | 1 | CPU control/status write pulse |
| winner_valid_o | output | 1 | A winner exists |
| winner_idx_o | output | log2(NUM_BUF) | Winner mailbox index |
| busy_o | output | 1 | Scan in progress |

## Verification
Some behaviour is checked by assertions on every cycle:
- frame events and idle-state CPU writes raise busy_o in the next cycle;
- any trigger restarts the scan at mailbox 0;
- the winner outputs stay stable while no scan is completing.

Other behaviour can only be shown by the bench's scenarios:
- the ranking under each mode;
- the exact on-wire key layout with its standard and extended padding;
- tie-breaking;
- the conditional intermission rule;
- the exact scan length.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  localparam int ID_W    = 29;
  localparam int EXT_W   = 18;
  localparam int STD_W   = ID_W - EXT_W;
  localparam int PRIO_W  = 3;
  localparam int WIRE_W  = STD_W + EXT_W + 3;
  localparam int KEY_W   = PRIO_W + WIRE_W;

  typedef logic [KEY_W-1:0] key_t;

  // On-wire ordering: base id, RTR/SRR, IDE, extension, RTR
  function automatic key_t make_key(input logic [ID_W-1:0] id,
                                    input logic ide, input logic rtr,
                                    input logic [PRIO_W-1:0] prio,
                                    input logic lowest_buf, input logic prio_en);
    logic [WIRE_W-1:0] wire_id;
    if (ide) wire_id = {id[ID_W-1:EXT_W], 1'b1, 1'b1, id[EXT_W-1:0], rtr};
    else     wire_id = {id[ID_W-1:EXT_W], rtr, 1'b0, {EXT_W{1'b0}}, 1'b0};
    if (lowest_buf) make_key = '0;
    else            make_key = {(prio_en ? prio : {PRIO_W{1'b0}}), wire_id};
  endfunction
endpackage

// File: rtl/tx_arb_trigger.sv
module tx_arb_trigger #(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ev_crc_i,
  input  logic               ev_err_delim_i,
  input  logic               ev_intermission_i,
  input  logic               ev_freeze_exit_i,
  input  logic               idle_or_busoff_i,
  input  logic               cpu_cs_wr_i,
  input  logic [NUM_BUF-1:0] active_i,
  input  logic               win_valid_i,
  input  logic [IDX_W-1:0]   win_idx_i,
  output logic               start_o
);
  logic wr_pend_q;
  logic inter_ok;

  always_comb begin
    inter_ok = (win_valid_i && !active_i[win_idx_i]) || (!win_valid_i && wr_pend_q);
    start_o  = ev_crc_i || ev_err_delim_i || ev_freeze_exit_i ||
               (idle_or_busoff_i && cpu_cs_wr_i) ||
               (ev_intermission_i && inter_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wr_pend_q <= 1'b0;
    else if (start_o)     wr_pend_q <= 1'b0;
    else if (cpu_cs_wr_i) wr_pend_q <= 1'b1;
  end
endmodule

// File: rtl/tx_arb_key_mux.sv
module tx_arb_key_mux
  import tx_arb_pkg::*;
#(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic [NUM_BUF-1:0]        active_i,
  input  logic [NUM_BUF*ID_W-1:0]   id_i,
  input  logic [NUM_BUF-1:0]        ide_i,
  input  logic [NUM_BUF-1:0]        rtr_i,
  input  logic [NUM_BUF*PRIO_W-1:0] prio_i,
  input  logic                      lowest_buf_i,
  input  logic                      prio_en_i,
  input  logic [IDX_W-1:0]          sel_i,
  output logic                      cand_active_o,
  output key_t                      cand_key_o
);
  key_t key_arr [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_key
    assign key_arr[g] = make_key(id_i[g*ID_W +: ID_W], ide_i[g], rtr_i[g],
                                 prio_i[g*PRIO_W +: PRIO_W], lowest_buf_i, prio_en_i);
  end

  assign cand_key_o    = key_arr[sel_i];
  assign cand_active_o = active_i[sel_i];
endmodule

// File: rtl/tx_arb_scan.sv
module tx_arb_scan
  import tx_arb_pkg::*;
#(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cand_active_i,
  input  key_t             cand_key_i,
  output logic [IDX_W-1:0] scan_idx_o,
  output logic             busy_o,
  output logic             win_valid_o,
  output logic [IDX_W-1:0] win_idx_o
);
  logic             busy_q, best_v_q, win_v_q;
  logic [IDX_W-1:0] idx_q, best_idx_q, win_idx_q;
  key_t             best_key_q;
  logic             take, last, best_v_n;
  logic [IDX_W-1:0] best_idx_n;
  key_t             best_key_n;

  always_comb begin
    // strict compare keeps the earlier (lower) index on ties
    take       = cand_active_i && (!best_v_q || (cand_key_i < best_key_q));
    best_v_n   = best_v_q || take;
    best_key_n = take ? cand_key_i : best_key_q;
    best_idx_n = take ? idx_q : best_idx_q;
    last       = (idx_q == IDX_W'(NUM_BUF-1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      best_v_q   <= 1'b0;
      best_key_q <= '0;
      best_idx_q <= '0;
      win_v_q    <= 1'b0;
      win_idx_q  <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      idx_q    <= '0;
      best_v_q <= 1'b0;
    end else if (busy_q) begin
      best_v_q   <= best_v_n;
      best_key_q <= best_key_n;
      best_idx_q <= best_idx_n;
      idx_q      <= idx_q + 1'b1;
      if (last) begin
        busy_q    <= 1'b0;
        win_v_q   <= best_v_n;
        win_idx_q <= best_idx_n;
      end
    end
  end

  assign scan_idx_o  = idx_q;
  assign busy_o      = busy_q;
  assign win_valid_o = win_v_q;
  assign win_idx_o   = win_idx_q;

  // R11
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && (idx_q == '0)));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> ($stable(win_v_q) && $stable(win_idx_q)));
endmodule

// File: rtl/tx_arb_top.sv
module tx_arb_top
  import tx_arb_pkg::*;
#(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BUF-1:0]        active_i,
  input  logic [NUM_BUF*ID_W-1:0]   id_i,
  input  logic [NUM_BUF-1:0]        ide_i,
  input  logic [NUM_BUF-1:0]        rtr_i,
  input  logic [NUM_BUF*PRIO_W-1:0] prio_i,
  input  logic                      lowest_buf_i,
  input  logic                      prio_en_i,
  input  logic                      ev_crc_i,
  input  logic                      ev_err_delim_i,
  input  logic                      ev_intermission_i,
  input  logic                      ev_freeze_exit_i,
  input  logic                      idle_or_busoff_i,
  input  logic                      cpu_cs_wr_i,
  output logic                      winner_valid_o,
  output logic [IDX_W-1:0]          winner_idx_o,
  output logic                      busy_o
);
  logic             start;
  logic             cand_active;
  key_t             cand_key;
  logic [IDX_W-1:0] scan_idx;

  tx_arb_trigger #(.NUM_BUF(NUM_BUF)) u_trigger (
    .clk_i, .rst_ni, .ev_crc_i, .ev_err_delim_i, .ev_intermission_i,
    .ev_freeze_exit_i, .idle_or_busoff_i, .cpu_cs_wr_i, .active_i,
    .win_valid_i(winner_valid_o), .win_idx_i(winner_idx_o), .start_o(start)
  );

  tx_arb_key_mux #(.NUM_BUF(NUM_BUF)) u_key_mux (
    .active_i, .id_i, .ide_i, .rtr_i, .prio_i, .lowest_buf_i, .prio_en_i,
    .sel_i(scan_idx), .cand_active_o(cand_active), .cand_key_o(cand_key)
  );

  tx_arb_scan #(.NUM_BUF(NUM_BUF)) u_scan (
    .clk_i, .rst_ni, .start_i(start), .cand_active_i(cand_active),
    .cand_key_i(cand_key), .scan_idx_o(scan_idx), .busy_o,
    .win_valid_o(winner_valid_o), .win_idx_o(winner_idx_o)
  );

  // R5
  frame_ev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_crc_i || ev_err_delim_i || ev_freeze_exit_i) |=> busy_o);

  // R7
  idle_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_or_busoff_i && cpu_cs_wr_i) |=> busy_o);
endmodule

// File: tb/tx_arb_top_tb.sv
`timescale 1ns/1ps
module tx_arb_top_tb;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NB-1:0]    active;
  logic [28:0]      ids [NB];
  logic [2:0]       prio [NB];
  logic [NB-1:0]    ide, rtr;
  logic [NB*29-1:0] id_flat;
  logic [NB*3-1:0]  prio_flat;
  logic lbuf, pen, e_crc, e_err, e_int, e_frz, idle, cpu_wr;
  logic win_v, busy;
  logic [3:0] win_idx;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      id_flat[i*29 +: 29] = ids[i];
      prio_flat[i*3 +: 3] = prio[i];
    end
  end

  tx_arb_top #(.NUM_BUF(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .active_i(active), .id_i(id_flat),
    .ide_i(ide), .rtr_i(rtr), .prio_i(prio_flat), .lowest_buf_i(lbuf),
    .prio_en_i(pen), .ev_crc_i(e_crc), .ev_err_delim_i(e_err),
    .ev_intermission_i(e_int), .ev_freeze_exit_i(e_frz),
    .idle_or_busoff_i(idle), .cpu_cs_wr_i(cpu_wr),
    .winner_valid_o(win_v), .winner_idx_o(win_idx), .busy_o(busy)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 crc, 1 err delim, 2 freeze exit, 3 intermission, 4 cpu write
  task automatic pulse(input int k);
    @(posedge clk); #1;
    case (k)
      0: e_crc = 1'b1;
      1: e_err = 1'b1;
      2: e_frz = 1'b1;
      3: e_int = 1'b1;
      default: cpu_wr = 1'b1;
    endcase
    @(posedge clk); #1;
    e_crc = 1'b0; e_err = 1'b0; e_frz = 1'b0; e_int = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic run_done(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (busy && n < 100);
  endtask

  task automatic scan(input int k);
    int n;
    pulse(k);
    run_done(n);
  endtask

  // {active[15:0], lbuf, pen, exp_valid, exp_idx[3:0]}
  localparam int NV = 11;
  localparam logic [22:0] VEC [NV] = '{
    {16'hFFFF, 1'b1, 1'b0, 1'b1, 4'd0},   // R1
    {16'hFFFF, 1'b1, 1'b1, 1'b1, 4'd0},   // R1 prio_en ignored
    {16'hFFFF, 1'b0, 1'b0, 1'b1, 4'd11},  // R2
    {16'hFFFF, 1'b0, 1'b1, 1'b1, 4'd7},   // R3
    {16'h0000, 1'b0, 1'b0, 1'b0, 4'd0},   // R8
    {16'hF000, 1'b1, 1'b0, 1'b1, 4'd12},  // R1
    {16'hF000, 1'b0, 1'b0, 1'b1, 4'd14},  // R2
    {16'hF000, 1'b0, 1'b1, 1'b1, 4'd15},  // R3
    {16'h00F0, 1'b0, 1'b1, 1'b1, 4'd7},   // R3
    {16'h0606, 1'b0, 1'b0, 1'b1, 4'd2},   // R2
    {16'h0606, 1'b0, 1'b1, 1'b1, 4'd2}    // R3 id breaks prio tie
  };

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < NB; i++) begin
      ids[i]  = {11'((i * 7 + 3) % 16), 18'h0};
      prio[i] = 3'(7 - (i % 8));
    end
    ide = '0; rtr = '0; active = '0; lbuf = 1'b0; pen = 1'b0;
    e_crc = 1'b0; e_err = 1'b0; e_int = 1'b0; e_frz = 1'b0;
    idle = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset valid", int'(win_v), 0);
    chk("R10 reset idx", int'(win_idx), 0);

    for (int v = 0; v < NV; v++) begin
      active = VEC[v][22:7];
      lbuf   = VEC[v][6];
      pen    = VEC[v][5];
      scan(0);
      chk($sformatf("R1/R2/R3/R8 vec%0d valid", v), int'(win_v), int'(VEC[v][4]));
      if (VEC[v][4]) chk($sformatf("R1/R2/R3 vec%0d idx", v), int'(win_idx), int'(VEC[v][3:0]));
    end

    // R10 scan length and output hold
    active = 16'hFFFF; lbuf = 1'b1; pen = 1'b0;
    scan(0);
    chk("R1 setup idx", int'(win_idx), 0);
    active = 16'hFFFE;
    pulse(0);
    chk("R5 crc busy", int'(busy), 1);
    repeat (5) @(posedge clk);
    chk("R10 hold during scan", int'(win_idx), 0);
    run_done(n);
    chk("R10 new idx", int'(win_idx), 1);
    pulse(1);
    chk("R5 err delim busy", int'(busy), 1);
    run_done(n);
    chk("R10 scan length", n, 16);
    pulse(2);
    chk("R5 freeze exit busy", int'(busy), 1);
    run_done(n);
    chk("R5 freeze result", int'(win_idx), 1);

    // R11 restart
    pulse(0);
    repeat (5) @(posedge clk);
    active = 16'hFFFC;
    pulse(0);
    run_done(n);
    chk("R11 restart length", n, 16);
    chk("R11 restart idx", int'(win_idx), 2);

    // R6 intermission rules
    pulse(3);
    chk("R6 winner active no scan", int'(busy), 0);
    active = 16'hFFF8;
    pulse(3);
    chk("R6 winner dropped scan", int'(busy), 1);
    run_done(n);
    chk("R6 new winner", int'(win_idx), 3);
    active = '0;
    scan(0);
    chk("R8 none active", int'(win_v), 0);
    pulse(3);
    chk("R6 no write no scan", int'(busy), 0);
    pulse(4);
    chk("R7 write not idle", int'(busy), 0);
    pulse(3);
    chk("R6 pending write scan", int'(busy), 1);
    run_done(n);
    chk("R8 still none", int'(win_v), 0);

    // R7 idle write
    idle = 1'b1;
    active = 16'h0100;
    pulse(4);
    chk("R7 idle write busy", int'(busy), 1);
    run_done(n);
    chk("R7 idle result", int'(win_idx), 8);
    idle = 1'b0;

    // R4 key layout
    lbuf = 1'b0; pen = 1'b0; active = 16'h0028;
    ids[3] = {11'h20, 18'h0}; ids[5] = {11'h20, 18'h0};
    ide[3] = 1'b1; ide[5] = 1'b0;
    scan(0);
    chk("R4 std beats ext", int'(win_idx), 5);
    ide[3] = 1'b0; rtr[3] = 1'b1; rtr[5] = 1'b0;
    scan(0);
    chk("R4 std rtr", int'(win_idx), 5);
    ide[3] = 1'b1; ide[5] = 1'b1;
    scan(0);
    chk("R4 ext rtr", int'(win_idx), 5);
    rtr[3] = 1'b0; ids[3] = {11'h20, 18'd5}; ids[5] = {11'h20, 18'd2};
    scan(0);
    chk("R4 ext bits", int'(win_idx), 5);
    ids[3] = {11'h10, 18'h3FFFF}; ids[5] = {11'h20, 18'h0}; ide[5] = 1'b0;
    scan(0);
    chk("R4 base id first", int'(win_idx), 3);

    // R9 tie
    ids[5] = ids[3]; ide[5] = ide[3]; rtr[5] = rtr[3]; prio[5] = prio[3];
    pen = 1'b1;
    scan(0);
    chk("R9 tie lower index", int'(win_idx), 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule